// File: doc/BRIEF.md
# SPI Management Register Target for an Ethernet Switch

This block lets a host processor configure a small Ethernet switch over a four-wire SPI link. The block is the SPI target, in mode 0. The host lowers chip select and sends a command byte and then an address byte. After that it either sends data bytes, which are stored in a 128-byte configuration space, or clocks out data bytes that the block shifts onto MISO. One frame may carry any number of data bytes. The address advances after each byte, so a single frame can cover a whole register group.

The register space has these parts:
- two identification bytes;
- ten global control bytes, brought out as a flat vector;
- a strided group of control and status bytes for each port. Three bits of each port's second control byte drive that port's transmit-enable, receive-enable and learning-disable outputs;
- eight indirect data bytes, brought out as one 64-bit word.

Bit 0 of the second identification byte is a soft start bit, and it drives the switch-enable output. After reset the block waits a set number of clock cycles and ignores any frame that begins before that time has passed.

The SPI pins are sampled in the system clock domain through synchronizers. The block runs on one clock only.

Top module: `spi_mgmt_regs`

## Requirements
- R1: Frames use SPI mode 0, MSB first, with MOSI sampled on rising SCLK. Command 0x02 followed by an address byte writes each following complete data byte to the current address.
- R2: Command 0x03 followed by an address byte returns the register at the current address on MISO, MSB first. Bit 7 is valid before the first rising SCLK of each data byte. At all other times, including while chip select is high, MISO is 0.
- R3: After each data byte the address advances by one and wraps from 0x7F to 0x00. Bit 7 of the address byte is ignored.
- R4: Address 0x00 always reads 0x95. Writes to it are ignored.
- R5: Address 0x01 reads {CHIP_ID[3:0], REV[2:0], start}. Only bit 0 (start) is writable. start resets to 0 and drives `switch_en_o`.
- R6: The control bytes of port p sit at 0x10+0x10*p+r, for r = 0..13. In byte r=2, bit 2 drives `port_tx_en_o[p]`, bit 1 drives `port_rx_en_o[p]` and bit 0 drives `port_learn_dis_o[p]`.
- R7: Address 0x1E+0x10*p reads `port_stat_i[16p+7:16p]`, and 0x1F+0x10*p reads `port_stat_i[16p+15:16p+8]`. Writes to these addresses are ignored.
- R8: Global control bytes 0x02..0x0B appear on `gctl_o`, with byte 0x02 in bits [7:0]. Indirect bytes 0x70..0x77 appear on `ind_data_o`, with 0x70 in bits [63:56]. All other non-identification, non-status bytes are plain read/write storage.
- R9: If chip select rises in the middle of a byte, that byte is discarded. Bytes completed earlier in the frame stay written.
- R10: A frame whose chip-select fall comes less than HOLD_US*CLK_MHZ clock cycles after reset release is ignored completely: nothing is written and MISO stays 0.
- R11: A command byte other than 0x02 or 0x03 makes the rest of the frame ignored, with no writes and MISO at 0.
- R12: After reset every writable byte is 0, so every control output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-target serial data |
| spi_miso | output | 1 | Target-to-host serial data, 0 when idle |
| port_stat_i | input | NPORTS*16 | Two status bytes per port |
| switch_en_o | output | 1 | Soft start bit |
| port_tx_en_o | output | NPORTS | Per-port transmit enable |
| port_rx_en_o | output | NPORTS | Per-port receive enable |
| port_learn_dis_o | output | NPORTS | Per-port address-learning disable |
| gctl_o | output | 80 | Global control bytes 0x02..0x0B |
| ind_data_o | output | 64 | Indirect data bytes 0x70..0x77 |

## Verification
The assertions assume that the host drives SCLK slowly compared with the system clock. Each SCLK level must last several clock cycles, so that at most one edge is seen per cycle and write strobes come one byte apart. MOSI may change only while SCLK is low, and SCLK must be low when chip select falls. The bench keeps each SCLK level for six clock cycles and changes MOSI just after each falling edge. Between frames it holds chip select high for twelve cycles, so the idle-MISO and write-origin properties are only checked against traffic of this kind.

// File: rtl/spi_mgmt_pkg.sv
package spi_mgmt_pkg;
    localparam logic [7:0] CMD_WRITE  = 8'h02;
    localparam logic [7:0] CMD_READ   = 8'h03;
    localparam logic [7:0] FAMILY_VAL = 8'h95;
    localparam int         REG_AW     = 7;
    localparam int         GCTL_BASE  = 2;
    localparam int         GCTL_N     = 10;
    localparam int         PORT_BASE  = 16;
    localparam int         PORT_STEP  = 16;
    localparam int         PCTL_LINK  = 2;
    localparam int         IND_BASE   = 8'h70;
    localparam int         IND_N      = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_DATA,
        PH_SKIP
    } phase_e;
endpackage

// File: rtl/spi_mgmt_sync.sv
module spi_mgmt_sync #(
    parameter int           N       = 3,
    parameter int           STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] lvl_o
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
            else        chain_q <= chain_d;
        end

        assign lvl_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/spi_mgmt_holdoff.sv
module spi_mgmt_holdoff #(
    parameter int HOLD_CYC = 20000
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready_o
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ready;
    } hold_s;

    hold_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.ready) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CW'(HOLD_CYC - 1)) st_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready_o = st_q.ready;

    // R10: once open, the access window never closes again
    a_r10_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ready |=> st_q.ready);
endmodule

// File: rtl/spi_mgmt_frame.sv
module spi_mgmt_frame
    import spi_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready_i,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic [7:0]        rd_data_i,
    output logic [REG_AW-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic [REG_AW-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              miso_o
);
    typedef struct packed {
        phase_e            ph;
        logic [2:0]        cnt;
        logic [6:0]        sh;
        logic [7:0]        tx;
        logic              miso;
        logic [REG_AW-1:0] addr;
        logic              rd;
        logic              wr;
        logic [REG_AW-1:0] waddr;
        logic [7:0]        wdata;
        logic              sclk_p;
    } frame_s;

    frame_s st_d, st_q;
    logic [7:0] byte_in;
    logic       rise, fall;

    always_comb begin
        byte_in   = {st_q.sh, mosi_i};
        rise      = sclk_i & ~st_q.sclk_p;
        fall      = ~sclk_i & st_q.sclk_p;
        rd_addr_o = (st_q.ph == PH_ADDR) ? byte_in[REG_AW-1:0]
                                         : REG_AW'(st_q.addr + 1'b1);

        st_d        = st_q;
        st_d.wr     = 1'b0;
        st_d.sclk_p = sclk_i;

        if (cs_n_i) begin
            st_d.ph   = PH_IDLE;
            st_d.cnt  = '0;
            st_d.miso = 1'b0;
            st_d.tx   = '0;
            st_d.rd   = 1'b0;
        end else if (st_q.ph == PH_IDLE) begin
            st_d.ph = ready_i ? PH_CMD : PH_SKIP;
        end else if (st_q.ph != PH_SKIP) begin
            if (rise) begin
                st_d.sh  = byte_in[6:0];
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == 3'd7) begin
                    unique case (st_q.ph)
                        PH_CMD: begin
                            if (byte_in == CMD_WRITE) begin
                                st_d.ph = PH_ADDR;
                                st_d.rd = 1'b0;
                            end else if (byte_in == CMD_READ) begin
                                st_d.ph = PH_ADDR;
                                st_d.rd = 1'b1;
                            end else begin
                                st_d.ph = PH_SKIP;
                            end
                        end
                        PH_ADDR: begin
                            st_d.addr = byte_in[REG_AW-1:0];
                            st_d.ph   = PH_DATA;
                            if (st_q.rd) st_d.tx = rd_data_i;
                        end
                        PH_DATA: begin
                            st_d.addr = REG_AW'(st_q.addr + 1'b1);
                            if (st_q.rd) begin
                                st_d.tx = rd_data_i;
                            end else begin
                                st_d.wr    = 1'b1;
                                st_d.waddr = st_q.addr;
                                st_d.wdata = byte_in;
                            end
                        end
                        default: ;
                    endcase
                end
            end else if (fall && st_q.ph == PH_DATA && st_q.rd) begin
                st_d.miso = st_q.tx[7];
                st_d.tx   = {st_q.tx[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign wr_en_o   = st_q.wr;
    assign wr_addr_o = st_q.waddr;
    assign wr_data_o = st_q.wdata;
    assign miso_o    = st_q.miso;

    // R2: MISO stays low while chip select is held high
    a_r2_miso_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && $past(cs_n_i)) |-> !miso_o);

    // R11: an ignored frame never produces a write strobe
    a_r11_skip_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_SKIP) |=> !wr_en_o);
endmodule

// File: rtl/spi_mgmt_regfile.sv
module spi_mgmt_regfile
    import spi_mgmt_pkg::*;
#(
    parameter int         NPORTS  = 5,
    parameter logic [3:0] CHIP_ID = 4'h0,
    parameter logic [2:0] REV     = 3'd2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [REG_AW-1:0]     wr_addr_i,
    input  logic [7:0]            wr_data_i,
    input  logic [REG_AW-1:0]     rd_addr_i,
    output logic [7:0]            rd_data_o,
    input  logic [NPORTS*16-1:0]  port_stat_i,
    output logic                  switch_en_o,
    output logic [NPORTS-1:0]     port_tx_en_o,
    output logic [NPORTS-1:0]     port_rx_en_o,
    output logic [NPORTS-1:0]     port_learn_dis_o,
    output logic [GCTL_N*8-1:0]   gctl_o,
    output logic [IND_N*8-1:0]    ind_data_o
);
    localparam int DEPTH = 1 << REG_AW;

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];
    logic [2:0] stat_port;

    function automatic logic is_status(input logic [REG_AW-1:0] a);
        return (a[3:1] == 3'b111) && (a[6:4] >= 3'd1) && (int'(a[6:4]) <= NPORTS);
    endfunction

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i && wr_addr_i != '0 && !is_status(wr_addr_i)) begin
            if (wr_addr_i == REG_AW'(1)) mem_d[1] = {7'd0, wr_data_i[0]};
            else                         mem_d[wr_addr_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        stat_port = rd_addr_i[6:4] - 3'd1;
        if (rd_addr_i == '0)                rd_data_o = FAMILY_VAL;
        else if (rd_addr_i == REG_AW'(1))   rd_data_o = {CHIP_ID, REV, mem_q[1][0]};
        else if (is_status(rd_addr_i))      rd_data_o = port_stat_i[{stat_port, rd_addr_i[0], 3'b000} +: 8];
        else                                rd_data_o = mem_q[rd_addr_i];
    end

    assign switch_en_o = mem_q[1][0];

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam int LINK_A = PORT_BASE + PORT_STEP * p + PCTL_LINK;
        assign port_tx_en_o[p]     = mem_q[LINK_A][2];
        assign port_rx_en_o[p]     = mem_q[LINK_A][1];
        assign port_learn_dis_o[p] = mem_q[LINK_A][0];
    end

    for (genvar g = 0; g < GCTL_N; g++) begin : g_gctl
        assign gctl_o[8*g +: 8] = mem_q[GCTL_BASE + g];
    end

    for (genvar k = 0; k < IND_N; k++) begin : g_ind
        assign ind_data_o[IND_N*8-1-8*k -: 8] = mem_q[IND_BASE + k];
    end

    // R5: the switch enable moves only after a write to the start byte
    a_r5_start_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(switch_en_o) |-> $past(wr_en_i && wr_addr_i == REG_AW'(1)));

    // R6: per-port link bits move only after a write to a port's link byte
    a_r6_link_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({port_tx_en_o, port_rx_en_o, port_learn_dis_o}) |->
        $past(wr_en_i && wr_addr_i[3:0] == 4'(PCTL_LINK) &&
              wr_addr_i[6:4] >= 3'd1 && int'(wr_addr_i[6:4]) <= NPORTS));
endmodule

// File: rtl/spi_mgmt_regs.sv
module spi_mgmt_regs
    import spi_mgmt_pkg::*;
#(
    parameter int         NPORTS  = 5,
    parameter logic [3:0] CHIP_ID = 4'h0,
    parameter logic [2:0] REV     = 3'd2,
    parameter int         CLK_MHZ = 200,
    parameter int         HOLD_US = 100,
    parameter int         SYNC_ST = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_sclk,
    input  logic                 spi_cs_n,
    input  logic                 spi_mosi,
    output logic                 spi_miso,
    input  logic [NPORTS*16-1:0] port_stat_i,
    output logic                 switch_en_o,
    output logic [NPORTS-1:0]    port_tx_en_o,
    output logic [NPORTS-1:0]    port_rx_en_o,
    output logic [NPORTS-1:0]    port_learn_dis_o,
    output logic [GCTL_N*8-1:0]  gctl_o,
    output logic [IND_N*8-1:0]   ind_data_o
);
    localparam int HOLD_CYC = CLK_MHZ * HOLD_US;

    logic [2:0]        pins_s;
    logic              ready;
    logic [REG_AW-1:0] rd_addr, wr_addr;
    logic [7:0]        rd_data, wr_data;
    logic              wr_en;

    spi_mgmt_sync #(.N(3), .STAGES(SYNC_ST), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_cs_n, spi_sclk, spi_mosi}),
        .lvl_o   (pins_s)
    );

    spi_mgmt_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready_o (ready)
    );

    spi_mgmt_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready_i   (ready),
        .cs_n_i    (pins_s[2]),
        .sclk_i    (pins_s[1]),
        .mosi_i    (pins_s[0]),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .miso_o    (spi_miso)
    );

    spi_mgmt_regfile #(.NPORTS(NPORTS), .CHIP_ID(CHIP_ID), .REV(REV)) u_regs (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_en_i          (wr_en),
        .wr_addr_i        (wr_addr),
        .wr_data_i        (wr_data),
        .rd_addr_i        (rd_addr),
        .rd_data_o        (rd_data),
        .port_stat_i      (port_stat_i),
        .switch_en_o      (switch_en_o),
        .port_tx_en_o     (port_tx_en_o),
        .port_rx_en_o     (port_rx_en_o),
        .port_learn_dis_o (port_learn_dis_o),
        .gctl_o           (gctl_o),
        .ind_data_o       (ind_data_o)
    );

    // R10: no register write can happen before the hold-off has elapsed
    a_r10_no_early_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ready);
endmodule

// File: tb/tb_spi_mgmt_regs.sv
`timescale 1ns/1ps
module tb_spi_mgmt_regs;
    localparam int         NP   = 5;
    localparam logic [3:0] CID  = 4'h0;
    localparam logic [2:0] RV   = 3'd2;
    localparam int         HOLD = 200 * 100;
    localparam int         H    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic [NP*16-1:0] stat = '0;
    logic switch_en;
    logic [NP-1:0] tx_en, rx_en, learn_dis;
    logic [79:0] gctl;
    logic [63:0] ind;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];
    logic [79:0] exp_gctl = '0;

    always #2.5 clk = ~clk;

    spi_mgmt_regs #(.NPORTS(NP), .CHIP_ID(CID), .REV(RV), .CLK_MHZ(200), .HOLD_US(100)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .port_stat_i(stat), .switch_en_o(switch_en),
        .port_tx_en_o(tx_en), .port_rx_en_o(rx_en), .port_learn_dis_o(learn_dis),
        .gctl_o(gctl), .ind_data_o(ind)
    );

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            @(negedge clk) mosi = tx[i];
            repeat (H) @(negedge clk);
            rx[i] = miso;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic spi_begin();
        @(negedge clk) cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic spi_end();
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (2*H) @(negedge clk);
    endtask

    task automatic wr_burst(input logic [7:0] a, input int n);
        logic [7:0] r;
        spi_begin();
        spi_bits(8'h02, 8, r);
        spi_bits(a, 8, r);
        for (int i = 0; i < n; i++) spi_bits(wbuf[i], 8, r);
        spi_end();
    endtask

    task automatic rd_burst(input logic [7:0] a, input int n);
        logic [7:0] r;
        spi_begin();
        spi_bits(8'h03, 8, r);
        spi_bits(a, 8, r);
        for (int i = 0; i < n; i++) begin
            spi_bits(8'h00, 8, r);
            rbuf[i] = r;
        end
        spi_end();
    endtask

    task automatic t_reset();
        chk("R12 reset gctl", gctl, '0);
        chk("R12 reset ind", ind, '0);
        chk("R12 reset port bits", {tx_en, rx_en, learn_dis}, '0);
        chk("R12 reset switch_en", switch_en, 0);
        chk("R2 idle miso", miso, 0);
    endtask

    task automatic t_holdoff();
        wbuf[0] = 8'hA5;
        wr_burst(8'h02, 1);
        chk("R10 early write ignored", gctl, '0);
        rd_burst(8'h00, 1);
        chk("R10 early read gives 0", rbuf[0], 8'h00);
        repeat (HOLD) @(negedge clk);
        rd_burst(8'h02, 1);
        chk("R10 location untouched", rbuf[0], 8'h00);
    endtask

    task automatic t_ident();
        rd_burst(8'h00, 2);
        chk("R4 family byte", rbuf[0], 8'h95);
        chk("R5 id byte", rbuf[1], {CID, RV, 1'b0});
        wbuf[0] = 8'h12; wbuf[1] = 8'hFF;
        wr_burst(8'h00, 2);
        chk("R5 start sets enable", switch_en, 1);
        rd_burst(8'h00, 2);
        chk("R4 family read-only", rbuf[0], 8'h95);
        chk("R5 upper bits fixed", rbuf[1], {CID, RV, 1'b1});
        wbuf[0] = 8'h00;
        wr_burst(8'h01, 1);
        chk("R5 stop clears enable", switch_en, 0);
    endtask

    task automatic t_gctl();
        for (int i = 0; i < 10; i++) begin
            wbuf[i] = 8'(8'h31 + 8'h17 * i);
            exp_gctl[8*i +: 8] = wbuf[i];
        end
        wr_burst(8'h02, 10);
        chk("R1 R8 burst write to gctl", gctl, exp_gctl);
        rd_burst(8'h02, 10);
        for (int i = 0; i < 10; i++) chk("R2 R3 burst read back", rbuf[i], exp_gctl[8*i +: 8]);
        wbuf[0] = 8'h3C;
        wr_burst(8'h82, 1);
        exp_gctl[7:0] = 8'h3C;
        chk("R3 address bit 7 ignored", gctl, exp_gctl);
    endtask

    task automatic t_ports();
        logic [7:0] v;
        logic [NP-1:0] etx, erx, eld;
        for (int p = 0; p < NP; p++) begin
            v = 8'hA8 | 8'((3*p + 1) % 8);
            etx[p] = v[2]; erx[p] = v[1]; eld[p] = v[0];
            wbuf[0] = v;
            wr_burst(8'(8'h12 + 16*p), 1);
            rd_burst(8'(8'h12 + 16*p), 1);
            chk("R6 link byte storage", rbuf[0], v);
        end
        chk("R6 tx enables", tx_en, etx);
        chk("R6 rx enables", rx_en, erx);
        chk("R6 learning disables", learn_dis, eld);
        wbuf[0] = 8'h5E;
        wr_burst(8'h1D, 1);
        rd_burst(8'h1D, 1);
        chk("R6 last port control byte", rbuf[0], 8'h5E);
    endtask

    task automatic t_status();
        for (int p = 0; p < NP; p++) stat[16*p +: 16] = 16'(16'h0F0E + 16'h1111 * p);
        for (int p = 0; p < NP; p++) begin
            rd_burst(8'(8'h1E + 16*p), 2);
            chk("R7 status low byte", rbuf[0], stat[16*p +: 8]);
            chk("R7 status high byte", rbuf[1], stat[16*p+8 +: 8]);
        end
        stat[15:0] = 16'hBEEF;
        wbuf[0] = 8'h00; wbuf[1] = 8'h00;
        wr_burst(8'h1E, 2);
        rd_burst(8'h1E, 2);
        chk("R7 status write ignored", {rbuf[1], rbuf[0]}, 16'hBEEF);
    endtask

    task automatic t_wrap();
        wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'h01;
        wr_burst(8'h7F, 3);
        chk("R3 wrap write reaches 0x01", switch_en, 1);
        rd_burst(8'h7F, 3);
        chk("R3 wrap 0x7F", rbuf[0], 8'hAA);
        chk("R3 wrap 0x00", rbuf[1], 8'h95);
        chk("R3 wrap 0x01", rbuf[2], {CID, RV, 1'b1});
    endtask

    task automatic t_indirect();
        for (int k = 0; k < 8; k++) wbuf[k] = 8'(8'hC1 + k);
        wr_burst(8'h70, 8);
        chk("R8 indirect word order", ind, 64'hC1C2C3C4C5C6C7C8);
    endtask

    task automatic t_abort();
        logic [7:0] r;
        spi_begin();
        spi_bits(8'h02, 8, r);
        spi_bits(8'h03, 8, r);
        spi_bits(8'h5A, 8, r);
        spi_bits(8'hFF, 4, r);
        spi_end();
        exp_gctl[15:8] = 8'h5A;
        chk("R9 partial byte dropped", gctl, exp_gctl);
    endtask

    task automatic t_badcmd();
        logic [7:0] r;
        logic [7:0] acc;
        acc = '0;
        spi_begin();
        spi_bits(8'h05, 8, r);
        spi_bits(8'h02, 8, r); acc |= r;
        spi_bits(8'h77, 8, r); acc |= r;
        spi_bits(8'h77, 8, r); acc |= r;
        spi_end();
        chk("R11 unknown command writes nothing", gctl, exp_gctl);
        chk("R11 unknown command miso low", acc, 8'h00);
        chk("R2 miso low after frame", miso, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_holdoff();
        t_ident();
        t_gctl();
        t_ports();
        t_status();
        t_wrap();
        t_indirect();
        t_abort();
        t_badcmd();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule